// File: doc/BRIEF.md
# Magic-Read Store Command Detector

This block sits beside a byte-wide memory bus, modelled as one access per clock cycle with a 13-bit address. It watches ordinary read traffic for a fixed series of six reads at chosen addresses. When the series completes, it emits a one-cycle pulse that tells the store engine to copy the volatile array into nonvolatile storage.

A write, or a read that does not match the next expected address, silently abandons the series. The pulse does not depend on whether any data has changed. The store engine reports back through a busy input. While that input is high, and in the cycle the pulse is high, the bus is treated as disabled and accesses have no effect on the detector.

The series, in the order it must arrive, is 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F.

Top module: `store_seq_detect`

## Requirements
- R1: While synchronous reset (`rst_n` low) is sampled at a clock edge, `seq_step` becomes 0 and `store_go` becomes 0.
- R2: The six reads 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F, accepted in that order, raise `store_go` for exactly one cycle, starting just after the edge that samples the sixth read.
- R3: `seq_step` equals the number of steps matched so far (0 to 5), and it returns to 0 on the edge that raises `store_go`.
- R4: An accepted read whose address differs from the next expected address clears `seq_step` to 0 and produces no pulse, unless R5 applies.
- R5: An aborting read to 0x0000 sets `seq_step` to 1, so that read begins a new series.
- R6: An accepted write (`acc_rd` = 0) at any address, including the expected address or 0x0000, clears `seq_step` to 0 and produces no pulse.
- R7: The address compare uses all 13 bits, so an address that differs from the expected one in any single bit aborts the series.
- R8: While `store_busy` is high, accesses are ignored and `seq_step` holds its value.
- R9: An access presented in the cycle where `store_go` is high is ignored, so `seq_step` stays 0.
- R10: The pulse is issued whether or not any write has taken place before the series, and a second series issued right after a pulse triggers again.
- R11: Cycles with `acc_vld` low between the reads of a series neither advance nor abort it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_vld | input | 1 | An access is presented in this cycle |
| acc_rd | input | 1 | 1 = read, 0 = write |
| acc_addr | input | 13 | Access address |
| store_busy | input | 1 | Store engine busy; accesses are ignored while it is high |
| store_go | output | 1 | One-cycle store trigger pulse |
| seq_step | output | 3 | Number of series steps matched so far |

## Verification
The bench builds the block with its default 13-bit address, which makes the whole address space small enough to sweep. Every one of the 8192 addresses is offered as the first read of a series, and again as the final read after five correct steps. This covers every near-miss of the trigger address and every aborting read that restarts the series at 0x0000. For the middle steps, each address is checked with every single bit flipped, and a write is placed at each position. Busy windows, idle gaps, the cycle in which the pulse is high and back-to-back series are also exercised, and every result is compared against a step model kept in the bench.

// File: rtl/store_seq_pkg.sv
package store_seq_pkg;

  // number of reads in the command series
  localparam int unsigned SEQ_LEN = 6;
  // width of the progress counter
  localparam int unsigned STEP_W = $clog2(SEQ_LEN);

  // address expected at series position idx (16 bits, truncated by users)
  function automatic logic [15:0] seq_code(input int idx);
    logic [15:0] c;
    case (idx)
      0:       c = 16'h0000;
      1:       c = 16'h1555;
      2:       c = 16'h0AAA;
      3:       c = 16'h1FFF;
      4:       c = 16'h10F0;
      default: c = 16'h0F0F;
    endcase
    return c;
  endfunction

  // step value after an abort: a read of the first code restarts the series
  function automatic logic [STEP_W-1:0] restart_step(input logic first_hit);
    return first_hit ? STEP_W'(1) : '0;
  endfunction

endpackage

// File: rtl/seq_match.sv
module seq_match
  import store_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [SEQ_LEN-1:0] hit_vec
);

  // one full-width comparator per series position
  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_cmp
    localparam logic [15:0] CODE = seq_code(i);
    assign hit_vec[i] = (addr == CODE[ADDR_W-1:0]);
  end

endmodule

// File: rtl/seq_gate.sv
module seq_gate (
  input  logic acc_vld,
  input  logic acc_rd,
  input  logic store_busy,
  input  logic store_go,
  output logic rd_ok,
  output logic wr_ok
);

  logic lockout;

  // the bus counts as disabled while the engine is busy or the pulse is out
  assign lockout = store_busy | store_go;
  assign rd_ok   = acc_vld &  acc_rd & ~lockout;
  assign wr_ok   = acc_vld & ~acc_rd & ~lockout;

endmodule

// File: rtl/seq_track.sv
module seq_track
  import store_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_ok,
  input  logic               wr_ok,
  input  logic [SEQ_LEN-1:0] hit_vec,
  output logic [STEP_W-1:0]  step,
  output logic               go,
  output logic               hit_cur
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0] step_nxt;
  logic              fire;

  // pick the comparator for the position now expected
  always_comb begin
    hit_cur = 1'b0;
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (step == STEP_W'(i)) hit_cur = hit_vec[i];
    end
  end

  always_comb begin
    step_nxt = step;
    fire     = 1'b0;
    if (wr_ok) begin
      step_nxt = '0;
    end else if (rd_ok) begin
      if (hit_cur) begin
        if (step == LAST) begin
          fire     = 1'b1;
          step_nxt = '0;
        end else begin
          step_nxt = step + STEP_W'(1);
        end
      end else begin
        step_nxt = restart_step(hit_vec[0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
      go   <= 1'b0;
    end else begin
      step <= step_nxt;
      go   <= fire;
    end
  end

  // R3
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST);

  // R2
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);

  // R2
  go_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ($past(step) == LAST && $past(rd_ok) && $past(hit_cur)));

  // R6
  wr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (step == '0 && !go));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !hit_cur && hit_vec[0]) |=> (step == STEP_W'(1)));

endmodule

// File: rtl/store_seq_detect.sv
module store_seq_detect
  import store_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              store_busy,
  output logic              store_go,
  output logic [STEP_W-1:0] seq_step
);

  logic [SEQ_LEN-1:0] hit_vec;
  logic               rd_ok;
  logic               wr_ok;
  logic               hit_cur;

  seq_match #(.ADDR_W(ADDR_W)) u_match (
    .addr    (acc_addr),
    .hit_vec (hit_vec)
  );

  seq_gate u_gate (
    .acc_vld    (acc_vld),
    .acc_rd     (acc_rd),
    .store_busy (store_busy),
    .store_go   (store_go),
    .rd_ok      (rd_ok),
    .wr_ok      (wr_ok)
  );

  seq_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_ok   (rd_ok),
    .wr_ok   (wr_ok),
    .hit_vec (hit_vec),
    .step    (seq_step),
    .go      (store_go),
    .hit_cur (hit_cur)
  );

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_busy |=> $stable(seq_step));

  // R9
  go_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |=> (seq_step == '0 && !store_go));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> ($stable(seq_step) && !store_go));

endmodule

// File: tb/test_store_seq_detect.sv
`timescale 1ns/1ps
module test_store_seq_detect;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_vld;
  logic        acc_rd;
  logic [12:0] acc_addr;
  logic        store_busy;
  logic        store_go;
  logic [2:0]  seq_step;

  int total = 0;
  int bad   = 0;

  // bench-side copy of the series from R2
  logic [12:0] codes [6];
  int exp_step = 0;
  int exp_go   = 0;

  always #10 clk = ~clk;

  store_seq_detect i_store_seq_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_vld    (acc_vld),
    .acc_rd     (acc_rd),
    .acc_addr   (acc_addr),
    .store_busy (store_busy),
    .store_go   (store_go),
    .seq_step   (seq_step)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive one cycle, update the model, then compare both outputs after the edge
  task automatic cyc(input logic v, input logic r, input logic [12:0] a, input string req);
    int ng;
    @(negedge clk);
    acc_vld  = v;
    acc_rd   = r;
    acc_addr = a;
    ng = 0;
    if (v && !store_busy && exp_go == 0) begin
      if (!r) exp_step = 0;
      else if (a == codes[exp_step]) begin
        if (exp_step == 5) begin ng = 1; exp_step = 0; end
        else exp_step = exp_step + 1;
      end else exp_step = (a == 13'h0000) ? 1 : 0;
    end
    exp_go = ng;
    @(posedge clk);
    #1;
    check({req, " step"}, int'(seq_step), exp_step);
    check({req, " go"}, int'(store_go), exp_go);
  endtask

  task automatic rd(input logic [12:0] a, input string req);
    cyc(1'b1, 1'b1, a, req);
  endtask

  task automatic run_to(input int k, input string req);
    for (int i = 0; i < k; i++) rd(codes[i], req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    codes[0] = 13'h0000; codes[1] = 13'h1555; codes[2] = 13'h0AAA;
    codes[3] = 13'h1FFF; codes[4] = 13'h10F0; codes[5] = 13'h0F0F;
    rst_n = 1'b0; acc_vld = 1'b0; acc_rd = 1'b1; acc_addr = '0; store_busy = 1'b0;
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    // R1 reset state
    check("R1 step", int'(seq_step), 0);
    check("R1 go", int'(store_go), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: no write since reset, series still triggers
    run_to(6, "R2_R3_R10");
    // R9: read of first code during the pulse cycle is ignored
    rd(13'h0000, "R9");
    cyc(1'b0, 1'b1, 13'h0, "R11");

    // R11: idle gaps between steps
    for (int i = 0; i < 6; i++) begin
      rd(codes[i], "R11");
      cyc(1'b0, 1'b1, codes[i], "R11");
      cyc(1'b0, 1'b0, 13'h1FFF, "R11");
    end

    // R10: back-to-back series after a pulse
    run_to(6, "R10");
    cyc(1'b0, 1'b1, 13'h0, "R10");
    run_to(6, "R10");
    cyc(1'b0, 1'b1, 13'h0, "R10");

    // R6: a write at each position, at the expected address and at 0x0000
    for (int k = 0; k < 6; k++) begin
      run_to(k, "R6");
      cyc(1'b1, 1'b0, codes[k], "R6");
      run_to(k, "R6");
      cyc(1'b1, 1'b0, 13'h0000, "R6");
    end

    // R7: single-bit flips at every position
    for (int k = 0; k < 6; k++) begin
      for (int b = 0; b < 13; b++) begin
        cyc(1'b1, 1'b0, 13'h0123, "R7");
        run_to(k, "R7");
        rd(codes[k] ^ (13'h1 << b), "R7");
      end
    end

    // R4/R5: every address as the first read
    for (int a = 0; a < 8192; a++) begin
      cyc(1'b1, 1'b0, 13'h1234, "R4");
      rd(13'(a), "R4_R5");
    end

    // R4/R5/R7: every address as the final read
    for (int a = 0; a < 8192; a++) begin
      cyc(1'b1, 1'b0, 13'h1234, "R4");
      run_to(5, "R3");
      rd(13'(a), "R4_R5_R7");
    end
    cyc(1'b0, 1'b1, 13'h0, "R11");

    // R8: busy holds progress against reads and writes
    run_to(3, "R8");
    store_busy = 1'b1;
    rd(codes[3], "R8");
    cyc(1'b1, 1'b0, 13'h0000, "R8");
    rd(13'h0000, "R8");
    run_to(6, "R8");
    store_busy = 1'b0;
    rd(codes[3], "R8");
    rd(codes[4], "R8");
    rd(codes[5], "R8_R2");
    cyc(1'b0, 1'b1, 13'h0, "R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule